// File: doc/BRIEF.md
# Key-Protected Interrupt Level Filter

This block holds a software-set interrupt threshold in a 32-bit register and uses it to decide, every cycle, whether any pending interrupt source may be taken. Each source brings a request bit, a 4-bit priority level and a mask bit. The CPU supplies its current 4-bit status-register mask level. A source qualifies only when its request is high, its mask bit is clear, and its level is strictly above both the stored threshold and the CPU level. Among the qualifying sources, the highest level wins and a tie goes to the lowest index. The non-maskable interrupt input bypasses every filter.

The register sits on a minimal write/read port. A write changes the threshold only when the top data byte carries a fixed key value. Any other write leaves the register unchanged. The decision is registered, so the accept flag, the NMI flag and the winning index appear one clock after the inputs that produced them.

Top module: `irq_level_filter`

## Requirements
- R1: `reg_rdata` always presents the threshold in bits 7:4 and zero in every other bit, including bits 31:24 (the key is never stored).
- R2: A write (`reg_we`=1) whose bits 31:24 equal 0xA5 loads bits 7:4 of `reg_wdata` into the threshold, visible on `reg_rdata` after that clock edge. All other write data bits are discarded.
- R3: A write whose bits 31:24 differ from 0xA5 leaves the threshold unchanged.
- R4: After reset the threshold is 0, `reg_rdata` is 0x00000000 and `acc_valid` is 0.
- R5: A source whose level is less than or equal to the threshold is never accepted. A source one level above the threshold can be accepted.
- R6: With threshold 0xF, no maskable source is accepted.
- R7: A source whose `src_msk` bit is 1 is never accepted.
- R8: A source is accepted only if its level is strictly greater than `sr_imask`.
- R9: Among qualifying sources, the one with the highest level is reported in `acc_idx`. Equal levels resolve to the lowest index. Source i's level is `src_lvl[4*i+3:4*i]`.
- R10: When `nmi` is 1, the next cycle shows `acc_valid`=1, `acc_nmi`=1 and `acc_idx`=0, whatever the threshold, `sr_imask` and the masks hold.
- R11: Outputs are registered: they reflect the inputs and threshold from before the previous clock edge. With no NMI and no qualifying source, `acc_valid` is 0, `acc_nmi` is 0 and `acc_idx` is 0.
- R12: Accepting an interrupt never changes the stored threshold. Only a keyed write does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on or manual) |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Write data; bits 31:24 key, bits 7:4 threshold |
| reg_rdata | output | 32 | Register read value |
| src_req | input | NUM_SRC | Per-source request |
| src_lvl | input | 4*NUM_SRC | Per-source priority levels, 4 bits each |
| src_msk | input | NUM_SRC | Per-source mask, 1 blocks the source |
| sr_imask | input | 4 | CPU status-register mask level |
| nmi | input | 1 | Non-maskable interrupt request |
| acc_valid | output | 1 | An interrupt is accepted |
| acc_nmi | output | 1 | The accepted interrupt is the NMI |
| acc_idx | output | $clog2(NUM_SRC) | Index of the accepted source |

## Verification
The bench drives requests at levels equal to, one below and one above the threshold. A design that compares with "greater or equal" would accept the equal case. It sends writes with near-miss keys (0xA4, 0x5A) and with noise in the unused data bits. A design with a loose key check would corrupt the threshold, and one that stores the whole word would echo garbage on read. It raises NMI with the threshold at 0xF, every mask set and a high CPU level, where a design that routes NMI through the filter would drop it. It also places tied and graded levels across indices, where a reversed scan order or a non-strict compare would report the wrong winner.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
    localparam int LVL_W    = 4;
    localparam int DATA_W   = 32;
    localparam int KEY_W    = 8;
    localparam int FIELD_LSB = 4;
    localparam logic [KEY_W-1:0] WR_KEY = 8'hA5;
    localparam logic [LVL_W-1:0] LVL_MAX = {LVL_W{1'b1}};

    typedef struct packed {
        logic [LVL_W-1:0] thresh;
    } thr_state_t;
endpackage

// File: rtl/irqf_key_reg.sv
module irqf_key_reg
    import irqf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [LVL_W-1:0]  thresh
);
    localparam int KEY_LSB = DATA_W - KEY_W;

    thr_state_t st_d, st_q;
    logic       key_ok;

    always_comb begin
        st_d   = st_q;
        key_ok = (wdata[DATA_W-1:KEY_LSB] == WR_KEY);
        if (we && key_ok) begin
            st_d.thresh = wdata[FIELD_LSB +: LVL_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        rdata[FIELD_LSB +: LVL_W] = st_q.thresh;
    end

    assign thresh = st_q.thresh;

    p_keyed_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wdata[DATA_W-1:KEY_LSB] == WR_KEY)
            |=> thresh == $past(wdata[FIELD_LSB +: LVL_W]));

    p_bad_key_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wdata[DATA_W-1:KEY_LSB] != WR_KEY) |=> $stable(thresh));

    p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(thresh));

    p_read_zeros_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[DATA_W-1:FIELD_LSB+LVL_W] == '0 && rdata[FIELD_LSB-1:0] == '0);
endmodule

// File: rtl/irqf_qualify.sv
module irqf_qualify
    import irqf_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic [NUM_SRC-1:0]       req,
    input  logic [NUM_SRC*LVL_W-1:0] lvl,
    input  logic [NUM_SRC-1:0]       msk,
    input  logic [LVL_W-1:0]         thresh,
    input  logic [LVL_W-1:0]         cpu_lvl,
    output logic [NUM_SRC-1:0]       qual
);
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        logic [LVL_W-1:0] my_lvl;
        logic             above_user;
        logic             above_cpu;
        always_comb begin
            my_lvl     = lvl[g*LVL_W +: LVL_W];
            above_user = (my_lvl > thresh);
            above_cpu  = (my_lvl > cpu_lvl);
            qual[g]    = req[g] & ~msk[g] & above_user & above_cpu;
        end
    end
endmodule

// File: rtl/irqf_arbiter.sv
module irqf_arbiter
    import irqf_pkg::*;
#(
    parameter int NUM_SRC = 8,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0]       qual,
    input  logic [NUM_SRC*LVL_W-1:0] lvl,
    output logic                     found,
    output logic [IDX_W-1:0]         win_idx
);
    logic [LVL_W-1:0] best_lvl;

    always_comb begin
        found    = 1'b0;
        win_idx  = '0;
        best_lvl = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (qual[i] && (!found || lvl[i*LVL_W +: LVL_W] > best_lvl)) begin
                found    = 1'b1;
                best_lvl = lvl[i*LVL_W +: LVL_W];
                win_idx  = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_level_filter.sv
module irq_level_filter
    import irqf_pkg::*;
#(
    parameter int NUM_SRC = 8,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_we,
    input  logic [31:0]              reg_wdata,
    output logic [31:0]              reg_rdata,
    input  logic [NUM_SRC-1:0]       src_req,
    input  logic [NUM_SRC*4-1:0]     src_lvl,
    input  logic [NUM_SRC-1:0]       src_msk,
    input  logic [3:0]               sr_imask,
    input  logic                     nmi,
    output logic                     acc_valid,
    output logic                     acc_nmi,
    output logic [IDX_W-1:0]         acc_idx
);
    typedef struct packed {
        logic             valid;
        logic             is_nmi;
        logic [IDX_W-1:0] idx;
    } dec_t;

    logic [LVL_W-1:0]   thresh;
    logic [NUM_SRC-1:0] qual;
    logic               found;
    logic [IDX_W-1:0]   win_idx;
    dec_t               dec_d, dec_q;

    irqf_key_reg u_key_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (reg_we),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .thresh (thresh)
    );

    irqf_qualify #(.NUM_SRC(NUM_SRC)) u_qualify (
        .req     (src_req),
        .lvl     (src_lvl),
        .msk     (src_msk),
        .thresh  (thresh),
        .cpu_lvl (sr_imask),
        .qual    (qual)
    );

    irqf_arbiter #(.NUM_SRC(NUM_SRC)) u_arbiter (
        .qual    (qual),
        .lvl     (src_lvl),
        .found   (found),
        .win_idx (win_idx)
    );

    always_comb begin
        dec_d = '0;
        if (nmi) begin
            dec_d.valid  = 1'b1;
            dec_d.is_nmi = 1'b1;
        end else if (found) begin
            dec_d.valid = 1'b1;
            dec_d.idx   = win_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q <= '0;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign acc_valid = dec_q.valid;
    assign acc_nmi   = dec_q.is_nmi;
    assign acc_idx   = dec_q.idx;

    function automatic logic [LVL_W-1:0] lvl_at(input logic [NUM_SRC*LVL_W-1:0] v,
                                                input logic [IDX_W-1:0] k);
        return v[k*LVL_W +: LVL_W];
    endfunction

    p_nmi_bypass_r10: assert property (@(posedge clk) disable iff (!rst_n)
        nmi |=> (acc_valid && acc_nmi && acc_idx == '0));

    p_full_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!nmi && thresh == LVL_MAX) |=> !acc_valid);

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!nmi && src_req == '0) |=> (!acc_valid && !acc_nmi && acc_idx == '0));

    p_above_thresh_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_nmi) |-> lvl_at($past(src_lvl), acc_idx) > $past(thresh));

    p_unmasked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_nmi) |-> !(($past(src_msk) >> acc_idx) & 1'b1));

    p_above_cpu_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_nmi) |-> lvl_at($past(src_lvl), acc_idx) > $past(sr_imask));

    p_nmi_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_nmi |-> acc_valid);
endmodule

// File: tb/irq_level_filter_bench.sv
module irq_level_filter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 8;
    localparam int IW = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_we = 1'b0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic [NS-1:0]   src_req = '0;
    logic [NS*4-1:0] src_lvl = '0;
    logic [NS-1:0]   src_msk = '0;
    logic [3:0]      sr_imask = '0;
    logic            nmi = 1'b0;
    logic            acc_valid, acc_nmi;
    logic [IW-1:0]   acc_idx;

    int vectors = 0;
    int misses = 0;
    int model_th = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_level_filter #(.NUM_SRC(NS)) u_irq_level_filter (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .src_req(src_req), .src_lvl(src_lvl),
        .src_msk(src_msk), .sr_imask(sr_imask), .nmi(nmi),
        .acc_valid(acc_valid), .acc_nmi(acc_nmi), .acc_idx(acc_idx)
    );

    task automatic check(string tag, int ev, int en, int ei, int er);
        vectors++;
        if (acc_valid !== ev[0] || acc_nmi !== en[0] || reg_rdata !== er ||
            (ev != 0 && acc_idx !== ei[IW-1:0])) begin
            misses++;
            $display("FAIL %s: valid=%0b nmi=%0b idx=%0d rdata=%h expected valid=%0d nmi=%0d idx=%0d rdata=%h",
                     tag, acc_valid, acc_nmi, acc_idx, reg_rdata, ev, en, ei, er);
        end
    endtask

    // behavioural reference: evaluate inputs, advance one clock, compare
    task automatic step(string tag);
        int ev = 0, en = 0, ei = 0, best = -1;
        if (nmi) begin
            ev = 1; en = 1; ei = 0;
        end else begin
            for (int i = 0; i < NS; i++) begin
                int l = int'(src_lvl[i*4 +: 4]);
                if (src_req[i] && !src_msk[i] && l > model_th && l > int'(sr_imask) && l > best) begin
                    best = l; ei = i; ev = 1;
                end
            end
        end
        if (reg_we && reg_wdata[31:24] == 8'hA5) model_th = int'(reg_wdata[7:4]);
        @(posedge clk);
        #1;
        check(tag, ev, en, ei, model_th << 4);
    endtask

    task automatic quiet();
        reg_we = 0; reg_wdata = '0; src_req = '0; src_lvl = '0;
        src_msk = '0; sr_imask = '0; nmi = 0;
    endtask

    task automatic wr(logic [31:0] d, string tag);
        quiet();
        reg_we = 1; reg_wdata = d;
        step(tag);
        reg_we = 0;
    endtask

    task automatic one_src(int idx, int lvl, string tag);
        quiet();
        src_req[idx] = 1'b1;
        src_lvl[idx*4 +: 4] = 4'(lvl);
        step(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        misses++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R4 reset", 0, 0, 0, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R4 after release", 0, 0, 0, 0);

        // R2 keyed write, R1 read layout
        wr(32'hA500_0050, "R2 good key");
        wr(32'hA5FF_FF3F, "R1 noise bits discarded");
        // R3 near-miss keys
        wr(32'hA400_00F0, "R3 key A4");
        wr(32'h5A00_0090, "R3 key 5A");
        wr(32'hA500_0050, "R2 reload 5");

        // R5 threshold edges, threshold = 5
        one_src(2, 5, "R5 equal level");
        one_src(2, 4, "R5 below level");
        one_src(2, 6, "R5 one above");
        one_src(7, 15, "R5 max level");

        // R7 per-source mask
        quiet(); src_req[3] = 1; src_lvl[12 +: 4] = 4'd9; src_msk[3] = 1; step("R7 masked");
        src_msk[3] = 0; step("R7 unmasked");
        // R8 cpu level
        sr_imask = 4'd9; step("R8 equal cpu level");
        sr_imask = 4'd8; step("R8 cpu level below");

        // R6 full mask, R10 nmi
        wr(32'hA500_00F0, "R2 load F");
        quiet(); src_req = '1; src_lvl = '1; step("R6 all sources blocked");
        nmi = 1; step("R10 nmi at threshold F");
        src_msk = '1; sr_imask = 4'hF; step("R10 nmi with every mask");

        // R9 arbitration, threshold 0
        wr(32'hA500_0000, "R2 load 0");
        quiet(); src_req = 8'b1010_1010; src_lvl = 32'h7000_7070; step("R9 tie lowest index");
        src_lvl = 32'h3080_6020; step("R9 highest level");
        src_req = '1; src_lvl = 32'h1111_1111; step("R9 all tied");
        src_msk = 8'h01; step("R9 tie skips masked");
        for (int k = 0; k < 4; k++) step("R12 repeated accept keeps threshold");

        quiet(); step("R11 idle");

        // random traffic against the model
        for (int n = 0; n < 3000; n++) begin
            reg_we    = ($urandom_range(0, 7) == 0);
            reg_wdata = {($urandom_range(0, 1) != 0) ? 8'hA5 : 8'($urandom), 24'($urandom)};
            src_req   = 8'($urandom);
            src_lvl   = 32'($urandom);
            src_msk   = 8'($urandom) & 8'($urandom);
            sr_imask  = 4'($urandom_range(0, 9));
            nmi       = ($urandom_range(0, 15) == 0);
            step("R9 random");
        end

        quiet();
        step("R11 final idle");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule